// File: doc/BRIEF.md
# Dual-Mode Branch Metric Unit

This block forms the branch metrics for a rate-1/2 trellis decoder. A single datapath serves both decoding styles and is steered by a mode input. In convolutional mode, each received sample pair is sliced to hard bits. The block then reports, for each of the four code-word hypotheses, how many bits differ. In turbo mode, it forms eight signed log-domain branch values. Each value combines half the a priori LLR, signed by the information-bit hypothesis, with the bipolar correlation of the systematic and parity samples against the hypothesised code bits. The channel reliability weight is assumed to be folded into the input scaling.

The eight lanes share one set of three-operand adders. The mode multiplexer selects their operands: either mismatch flags or signed samples. The results are registered and passed straight on to the state-metric units; nothing is stored. Sixteen trellis branches per symbol of an 8-state trellis read from these eight values. A small state machine tracks what the output register currently holds. It has three states: `S_IDLE` (no fresh result), `S_VIT` (convolutional result) and `S_TRB` (turbo result). On every clock it moves to `S_VIT` if a symbol arrives with mode 0, to `S_TRB` if a symbol arrives with mode 1, and to `S_IDLE` if no symbol arrives. `out_valid` is high in the two result states.

Top module: `dm_branch_metric`

## Requirements
- R1: After reset, `out_valid` is 0 and all eight metric fields of `out_bm` are 0.
- R2: `out_valid` is 1 exactly in the cycle after a clock edge that sampled `in_valid` = 1. The metrics change only on such edges and hold their value otherwise.
- R3: Convolutional mode (`in_mode` = 0): the hard bit of a sample is its sign bit (negative means 1). Field k, for k = 0..3, equals the count of mismatches between hypothesis bit k[1] and the systematic hard bit, plus k[0] and the parity hard bit. The result is always in 0..2.
- R4: In convolutional mode, fields 4..7 are 0.
- R5: Turbo mode (`in_mode` = 1): field k equals ±h ± sys ± par. Here k[2] selects the sign of h, k[1] the sign of sys and k[0] the sign of par. A bit of 0 means + and a bit of 1 means −. The value h is the halved a priori term.
- R6: h is the a priori input shifted right by one with sign fill, so it rounds toward minus infinity (−3 gives −2, 5 gives 2).
- R7: In turbo mode, field k is the exact negation of field 7−k.
- R8: Full-scale inputs (samples −8 or 7, a priori −128 or 127) give exact results, with no wrap in the 10-bit fields.
- R9: The mode is sampled together with each symbol, so consecutive symbols may alternate modes and each result follows its own symbol's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol present this cycle |
| in_mode | input | 1 | 0 = convolutional, 1 = turbo |
| in_sys | input | 4 | Signed systematic sample |
| in_par | input | 4 | Signed parity sample |
| in_apri | input | 8 | Signed a priori LLR |
| out_valid | output | 1 | Metrics refreshed last edge |
| out_bm | output | 80 | Eight signed 10-bit metrics, field k at bits [10k+9:10k] |

## Verification
On every cycle, the assertions check four things. The valid timing and the hold of the metrics are checked. The convolutional results must stay in 0..2, with complementary hypotheses summing to 2, and the upper fields must be zero. The turbo results must be pairwise negations. These checks cannot tell a wrong but symmetric value from a right one. The exact sign convention, the rounding of the halved a priori term, the hard-slice threshold at zero, full-scale behaviour and mode alternation can only be confirmed by the bench scenarios, which compare against independently computed values.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int SMP_W_DEF = 4;
    localparam int APR_W_DEF = 8;
    localparam int N_HYP     = 8;
    localparam int N_VIT     = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_VIT  = 2'd1,
        S_TRB  = 2'd2
    } bmu_state_t;
endpackage

// File: rtl/bmu_prep.sv
module bmu_prep #(
    parameter int SMP_W = 4,
    parameter int APR_W = 8,
    parameter int BM_W  = 10
) (
    input  logic [SMP_W-1:0]       sys_i,
    input  logic [SMP_W-1:0]       par_i,
    input  logic [APR_W-1:0]       apri_i,
    output logic signed [BM_W-1:0] sys_x,
    output logic signed [BM_W-1:0] par_x,
    output logic signed [BM_W-1:0] half_x,
    output logic                   hard_sys,
    output logic                   hard_par
);
    logic signed [APR_W-1:0] half_n;

    always_comb begin
        half_n   = $signed(apri_i) >>> 1;
        half_x   = {{(BM_W-APR_W){half_n[APR_W-1]}}, half_n};
        sys_x    = {{(BM_W-SMP_W){sys_i[SMP_W-1]}}, sys_i};
        par_x    = {{(BM_W-SMP_W){par_i[SMP_W-1]}}, par_i};
        hard_sys = sys_i[SMP_W-1];
        hard_par = par_i[SMP_W-1];
    end
endmodule

// File: rtl/bmu_lane.sv
module bmu_lane #(
    parameter int IDX  = 0,
    parameter int BM_W = 10
) (
    input  logic                   mode_i,
    input  logic signed [BM_W-1:0] sys_x,
    input  logic signed [BM_W-1:0] par_x,
    input  logic signed [BM_W-1:0] half_x,
    input  logic                   hard_sys,
    input  logic                   hard_par,
    output logic signed [BM_W-1:0] bm_o
);
    localparam logic HU = 1'((IDX >> 2) & 1);
    localparam logic HS = 1'((IDX >> 1) & 1);
    localparam logic HP = 1'(IDX & 1);

    logic signed [BM_W-1:0] op_a, op_b, op_c;

    generate
        if (IDX < bmu_pkg::N_VIT) begin : g_dual
            always_comb begin
                if (mode_i) begin
                    op_a = HU ? -half_x : half_x;
                    op_b = HS ? -sys_x  : sys_x;
                    op_c = HP ? -par_x  : par_x;
                end else begin
                    op_a = '0;
                    op_b = {{(BM_W-1){1'b0}}, hard_sys ^ HS};
                    op_c = {{(BM_W-1){1'b0}}, hard_par ^ HP};
                end
            end
        end else begin : g_soft_only
            always_comb begin
                op_a = mode_i ? (HU ? -half_x : half_x) : '0;
                op_b = mode_i ? (HS ? -sys_x  : sys_x)  : '0;
                op_c = mode_i ? (HP ? -par_x  : par_x)  : '0;
            end
        end
    endgenerate

    assign bm_o = op_a + op_b + op_c;
endmodule

// File: rtl/dm_branch_metric.sv
module dm_branch_metric #(
    parameter int SMP_W = bmu_pkg::SMP_W_DEF,
    parameter int APR_W = bmu_pkg::APR_W_DEF
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic                                   in_mode,
    input  logic [SMP_W-1:0]                       in_sys,
    input  logic [SMP_W-1:0]                       in_par,
    input  logic [APR_W-1:0]                       in_apri,
    output logic                                   out_valid,
    output logic [bmu_pkg::N_HYP*(((APR_W > SMP_W) ? APR_W : SMP_W) + 2)-1:0] out_bm
);
    import bmu_pkg::*;

    localparam int BM_W = ((APR_W > SMP_W) ? APR_W : SMP_W) + 2;

    logic signed [BM_W-1:0] sys_x, par_x, half_x;
    logic                   hard_sys, hard_par;
    logic signed [BM_W-1:0] bm_d [N_HYP];
    logic signed [BM_W-1:0] bm_q [N_HYP];
    bmu_state_t             state, state_nx;

    bmu_prep #(.SMP_W(SMP_W), .APR_W(APR_W), .BM_W(BM_W)) u_prep (
        .sys_i    (in_sys),
        .par_i    (in_par),
        .apri_i   (in_apri),
        .sys_x    (sys_x),
        .par_x    (par_x),
        .half_x   (half_x),
        .hard_sys (hard_sys),
        .hard_par (hard_par)
    );

    generate
        for (genvar k = 0; k < N_HYP; k++) begin : g_lane
            bmu_lane #(.IDX(k), .BM_W(BM_W)) u_lane (
                .mode_i   (in_mode),
                .sys_x    (sys_x),
                .par_x    (par_x),
                .half_x   (half_x),
                .hard_sys (hard_sys),
                .hard_par (hard_par),
                .bm_o     (bm_d[k])
            );
            assign out_bm[k*BM_W +: BM_W] = bm_q[k];
        end
    endgenerate

    // next-state selection
    always_comb begin
        unique case ({in_valid, in_mode})
            2'b10:   state_nx = S_VIT;
            2'b11:   state_nx = S_TRB;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_HYP; k++) bm_q[k] <= '0;
        end else if (in_valid) begin
            for (int k = 0; k < N_HYP; k++) bm_q[k] <= bm_d[k];
        end
    end

    assign out_valid = (state != S_IDLE);

    // ---------------- assertions ----------------
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bm));
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VIT) |-> (out_bm[N_HYP*BM_W-1 : N_VIT*BM_W] == '0));
    p_vit_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VIT) |-> ((bm_q[0] + bm_q[3] == BM_W'(2)) && (bm_q[1] + bm_q[2] == BM_W'(2))));

    generate
        for (genvar k = 0; k < N_VIT; k++) begin : g_chk_vit
            p_vit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (state == S_VIT) |-> (bm_q[k] >= 0 && bm_q[k] <= 2));
        end
        for (genvar k = 0; k < N_VIT; k++) begin : g_chk_trb
            p_trb_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (state == S_TRB) |-> (bm_q[k] + bm_q[N_HYP-1-k] == '0));
        end
    endgenerate
endmodule

// File: tb/sim_dm_branch_metric.sv
`timescale 1ns/1ps
module sim_dm_branch_metric;
    localparam int BW = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [3:0]  in_sys = '0;
    logic [3:0]  in_par = '0;
    logic [7:0]  in_apri = '0;
    logic        out_valid;
    logic [8*BW-1:0] out_bm;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dm_branch_metric u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_sys(in_sys), .in_par(in_par), .in_apri(in_apri),
        .out_valid(out_valid), .out_bm(out_bm)
    );

    // {mode, sys, par, apri}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'd3,  4'd5,  8'd0},
        {1'b0, 4'hF,  4'd2,  8'd0},
        {1'b0, 4'd1,  4'hC,  8'd0},
        {1'b0, 4'h8,  4'h8,  8'd0},
        {1'b0, 4'd0,  4'd0,  8'd77},
        {1'b1, 4'd3,  4'd5,  8'd10},
        {1'b1, 4'hD,  4'd2,  8'hF6},
        {1'b1, 4'd7,  4'h9,  8'd33},
        {1'b1, 4'd0,  4'd0,  8'd0},
        {1'b1, 4'h8,  4'h8,  8'h80},
        {1'b1, 4'd7,  4'd7,  8'd127},
        {1'b0, 4'd7,  4'h8,  8'h80}
    };

    function automatic logic [8*BW-1:0] model(input logic m, input logic [3:0] s,
                                             input logic [3:0] p, input logic [7:0] a);
        logic [8*BW-1:0] r;
        int si, pi, h, v;
        si = int'($signed(s));
        pi = int'($signed(p));
        h  = int'($signed(a)) >>> 1;
        r  = '0;
        for (int k = 0; k < 8; k++) begin
            if (m) begin
                v = (((k >> 2) & 1) != 0 ? -h : h)
                  + (((k >> 1) & 1) != 0 ? -si : si)
                  + ((k & 1) != 0 ? -pi : pi);
            end else if (k < 4) begin
                v = ((((k >> 1) & 1) != int'(s[3])) ? 1 : 0)
                  + ((((k & 1)) != int'(p[3])) ? 1 : 0);
            end else begin
                v = 0;
            end
            r[k*BW +: BW] = BW'(v);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [8*BW-1:0] act,
                       input logic [8*BW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic m, input logic [3:0] s, input logic [3:0] p,
                        input logic [7:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_sys = s; in_par = p; in_apri = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [8*BW-1:0] e, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 valid", {79'd0, out_valid}, '0);
        chk(out_bm == '0, "R1 metrics", out_bm, '0);

        // table walk: R3/R4 in conv mode, R5/R7/R8 in turbo mode
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:0]);
            e = model(VEC[i][16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:0]);
            chk(out_valid == 1'b1, "R2 valid", {79'd0, out_valid}, {79'd0, 1'b1});
            chk(out_bm == e, VEC[i][16] ? "R5" : "R3", out_bm, e);
        end

        // R4: conv after turbo clears upper fields
        send(1'b1, 4'd5, 4'd6, 8'd40);
        send(1'b0, 4'd5, 4'd6, 8'd40);
        chk(out_bm[8*BW-1:4*BW] == '0, "R4 upper zero", out_bm, {40'd0, out_bm[4*BW-1:0]});

        // R2 hold: no valid, inputs change
        held = out_bm;
        @(negedge clk);
        in_mode = 1'b1; in_sys = 4'd7; in_apri = 8'd99;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 idle", {79'd0, out_valid}, '0);
        chk(out_bm == held, "R2 hold", out_bm, held);

        // R6: apri -3 -> h=-2 ; apri 5 -> h=2
        send(1'b1, 4'd0, 4'd0, 8'hFD);
        e = model(1'b1, 4'd0, 4'd0, 8'hFD);
        chk($signed(out_bm[BW-1:0]) == -2, "R6 round neg", out_bm, e);
        send(1'b1, 4'd0, 4'd0, 8'd5);
        chk($signed(out_bm[BW-1:0]) == 2, "R6 round pos", out_bm, model(1'b1, 4'd0, 4'd0, 8'd5));

        // R8 full scale
        send(1'b1, 4'h8, 4'h8, 8'h80);
        chk($signed(out_bm[7*BW +: BW]) == 80 && $signed(out_bm[0 +: BW]) == -80,
            "R8 min scale", out_bm, model(1'b1, 4'h8, 4'h8, 8'h80));
        send(1'b1, 4'd7, 4'd7, 8'd127);
        chk($signed(out_bm[0 +: BW]) == 77, "R8 max scale", out_bm, model(1'b1, 4'd7, 4'd7, 8'd127));

        // R7 symmetry on a turbo result
        send(1'b1, 4'hB, 4'd4, 8'd21);
        begin
            bit ok = 1'b1;
            for (int k = 0; k < 4; k++)
                if ($signed(out_bm[k*BW +: BW]) != -$signed(out_bm[(7-k)*BW +: BW])) ok = 1'b0;
            chk(ok, "R7 symmetry", out_bm, model(1'b1, 4'hB, 4'd4, 8'd21));
        end

        // R9 back-to-back symbols alternating mode
        @(negedge clk);
        in_valid = 1'b1; in_mode = 1'b0; in_sys = 4'hF; in_par = 4'd1; in_apri = 8'd50;
        @(negedge clk);
        e = model(1'b0, 4'hF, 4'd1, 8'd50);
        chk(out_bm == e && out_valid, "R9 conv step", out_bm, e);
        in_mode = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = model(1'b1, 4'hF, 4'd1, 8'd50);
        chk(out_bm == e && out_valid, "R9 turbo step", out_bm, e);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule